// File: doc/BRIEF.md
# Timed Video to Stream Formatter

This block sits at the pixel-clock input of a video pipeline. Parallel pixel data arrives together with explicit timing lines: a data enable, horizontal and vertical sync, and horizontal and vertical blank. The block turns that into stream beats. Each beat carries padded pixel data, a valid flag, a start-of-frame flag and an end-of-line flag, and a downstream buffer takes the beats. Pixels with the data enable low are removed before they reach the stream.

The end of a line is found by looking one pixel ahead. A pixel marks the end of its line when the data enable is low on the next pixel clock. The start of a frame is armed by a rising edge of vertical sync and lands on the next active pixel.

Components narrower than a byte multiple are widened to the next multiple of 8 bits. The zero bits go below each component. The four sync and blank lines are copied out with the same two-cycle delay as the beats, for an external timing detector.

Top module: `vid_beat_formatter`

## Requirements
- R1: All timing inputs are active high. A beat is produced (`beat_valid` = 1) exactly when `pix_de` was high on the pixel clock two edges earlier. The pixel is captured on the first edge and presented after the second.
- R2: A pixel sampled with `pix_de` low produces no beat. While `beat_valid` is 0, `beat_data` is all zeros.
- R3: `beat_eol` is 1 on a beat exactly when `pix_de` is low on the pixel clock right after that beat's pixel. The flag therefore never lasts more than one beat.
- R4: A rising edge of `pix_vsync` arms a pending start-of-frame. The first pixel with `pix_de` high, on that same clock or later, carries `beat_sof` = 1, which clears the pending state. No other beat carries it.
- R5: Component i sits in input bits [i*COMP_BITS +: COMP_BITS]. It lands in output field [i*FIELD_W +: FIELD_W], where FIELD_W = COMP_BITS rounded up to a multiple of 8. The component fills the top COMP_BITS bits of its field and the lower FIELD_W-COMP_BITS bits are zero.
- R6: `tap_hsync`, `tap_vsync`, `tap_hblank` and `tap_vblank` equal `pix_hsync`, `pix_vsync`, `pix_hblank` and `pix_vblank` from two edges earlier.
- R7: Synchronous reset `rst` sets all outputs to 0 and clears any pending start-of-frame. A vertical sync that is already high when reset ends does not count as an edge. No `beat_sof` appears until a new rising edge of `pix_vsync` is seen.
- R8: The input width COMP_BITS*COMP_COUNT lies between 8 and 64 bits, and the output width is a whole multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_de | input | 1 | Data enable, active high |
| pix_hsync | input | 1 | Horizontal sync, active high |
| pix_vsync | input | 1 | Vertical sync, active high |
| pix_hblank | input | 1 | Horizontal blank, active high |
| pix_vblank | input | 1 | Vertical blank, active high |
| pix_data | input | COMP_BITS*COMP_COUNT | Packed pixel components |
| beat_valid | output | 1 | Beat present |
| beat_sof | output | 1 | First beat of a frame |
| beat_eol | output | 1 | Last beat of a line |
| beat_data | output | FIELD_W*COMP_COUNT | Padded pixel data |
| tap_hsync | output | 1 | Delayed horizontal sync |
| tap_vsync | output | 1 | Delayed vertical sync |
| tap_hblank | output | 1 | Delayed horizontal blank |
| tap_vblank | output | 1 | Delayed vertical blank |

## Verification
The assertions assume that every input is a clean synchronous level on the pixel clock. The two-deep history checks assume at least two clocks have passed since reset, and a warm-up counter guards them. The stimulus changes inputs only well after a rising edge. It builds frames from vertical blank, a sync pulse and lines of one to six pixels with one- or three-clock gaps. A reset mid-line, held while vertical sync is high, confirms that no frame start appears without a fresh sync edge.

// File: rtl/vid_beat_formatter.sv
module vid_beat_formatter #(
  parameter int COMP_BITS  = 10,
  parameter int COMP_COUNT = 3,
  localparam int IN_W    = COMP_BITS * COMP_COUNT,
  localparam int FIELD_W = ((COMP_BITS + 7) / 8) * 8,
  localparam int PAD_W   = FIELD_W - COMP_BITS,
  localparam int OUT_W   = FIELD_W * COMP_COUNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_de,
  input  logic             pix_hsync,
  input  logic             pix_vsync,
  input  logic             pix_hblank,
  input  logic             pix_vblank,
  input  logic [IN_W-1:0]  pix_data,
  output logic             beat_valid,
  output logic             beat_sof,
  output logic             beat_eol,
  output logic [OUT_W-1:0] beat_data,
  output logic             tap_hsync,
  output logic             tap_vsync,
  output logic             tap_hblank,
  output logic             tap_vblank
);

  logic            s1_de, s1_sof;
  logic [IN_W-1:0] s1_data;
  logic [3:0]      s1_tim;
  logic            vs_prev, sof_pend;
  logic            vs_rise;
  logic [OUT_W-1:0] padded;

  assign vs_rise = pix_vsync & ~vs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_de    <= 1'b0;
      s1_sof   <= 1'b0;
      s1_data  <= '0;
      s1_tim   <= '0;
      vs_prev  <= 1'b1;
      sof_pend <= 1'b0;
    end else begin
      s1_de   <= pix_de;
      s1_data <= pix_data;
      s1_tim  <= {pix_vblank, pix_hblank, pix_vsync, pix_hsync};
      vs_prev <= pix_vsync;
      if (pix_de && (sof_pend || vs_rise)) begin
        s1_sof   <= 1'b1;
        sof_pend <= 1'b0;
      end else begin
        s1_sof <= 1'b0;
        if (vs_rise) sof_pend <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < COMP_COUNT; i++) begin : g_field
    if (PAD_W == 0) begin : g_exact
      assign padded[i*FIELD_W +: FIELD_W] = s1_data[i*COMP_BITS +: COMP_BITS];
    end else begin : g_pad
      assign padded[i*FIELD_W +: FIELD_W] = {s1_data[i*COMP_BITS +: COMP_BITS], {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_sof   <= 1'b0;
      beat_eol   <= 1'b0;
      beat_data  <= '0;
      {tap_vblank, tap_hblank, tap_vsync, tap_hsync} <= '0;
    end else begin
      beat_valid <= s1_de;
      beat_sof   <= s1_sof;
      beat_eol   <= s1_de & ~pix_de;
      beat_data  <= s1_de ? padded : '0;
      {tap_vblank, tap_hblank, tap_vsync, tap_hsync} <= s1_tim;
    end
  end

  logic [1:0] warm;
  logic       armed;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end
  assign armed = (warm == 2'd2);

  p_valid_from_de_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> beat_valid == $past(pix_de, 2));
  p_eol_lookahead_r3: assert property (@(posedge clk) disable iff (rst)
    armed && beat_eol |-> !$past(pix_de, 1));
  p_eol_single_r3: assert property (@(posedge clk) disable iff (rst)
    beat_eol |=> !beat_eol);
  p_sof_on_beat_r4: assert property (@(posedge clk) disable iff (rst)
    beat_sof |-> beat_valid);
  p_top_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    armed && beat_valid |-> beat_data[FIELD_W-1 -: COMP_BITS] == $past(pix_data[COMP_BITS-1:0], 2));
  p_tap_delay_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> tap_vsync == $past(pix_vsync, 2) && tap_hsync == $past(pix_hsync, 2)
           && tap_vblank == $past(pix_vblank, 2) && tap_hblank == $past(pix_hblank, 2));
  p_width_r8: assert final (IN_W >= 8 && IN_W <= 64 && OUT_W % 8 == 0);

endmodule

// File: tb/test_vid_beat_formatter.sv
module test_vid_beat_formatter;
  logic clk = 0, rst = 1;
  logic pix_de = 0, pix_hsync = 0, pix_vsync = 0, pix_hblank = 0, pix_vblank = 0;
  logic [29:0] pix_data = '0;
  logic beat_valid, beat_sof, beat_eol;
  logic [47:0] beat_data;
  logic tap_hsync, tap_vsync, tap_hblank, tap_vblank;
  int checks = 0, fails = 0, seed = 1;

  always #4 clk = ~clk;

  vid_beat_formatter #(.COMP_BITS(10), .COMP_COUNT(3)) i_vid_beat_formatter (
    .clk, .rst, .pix_de, .pix_hsync, .pix_vsync, .pix_hblank, .pix_vblank, .pix_data,
    .beat_valid, .beat_sof, .beat_eol, .beat_data,
    .tap_hsync, .tap_vsync, .tap_hblank, .tap_vblank);

  logic p_de = 0, p_sof = 0, m_pend = 0, m_vsprev = 1;
  logic [29:0] p_data = '0;
  logic [3:0] p_tim = '0;

  function automatic logic [47:0] pad(input logic [29:0] d);
    logic [47:0] r = '0;
    for (int i = 0; i < 3; i++) r |= 48'((d >> (i * 10)) & 30'h3FF) << (i * 16 + 6);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic de, input logic hs, input logic vs, input logic hb,
                      input logic vb, input logic [29:0] d);
    logic e_valid, e_sof, e_eol, rise, n_sof;
    logic [47:0] e_data;
    logic [3:0] e_tim;
    pix_de = de; pix_hsync = hs; pix_vsync = vs; pix_hblank = hb; pix_vblank = vb; pix_data = d;
    @(posedge clk);
    if (rst) begin
      e_valid = 0; e_sof = 0; e_eol = 0; e_data = '0; e_tim = '0;
      p_de = 0; p_sof = 0; p_data = '0; p_tim = '0; m_pend = 0; m_vsprev = 1;
    end else begin
      e_valid = p_de; e_sof = p_sof; e_eol = p_de & ~de;
      e_data = p_de ? pad(p_data) : '0; e_tim = p_tim;
      rise = vs & ~m_vsprev;
      n_sof = 0;
      if (de && (m_pend || rise)) begin n_sof = 1; m_pend = 0; end
      else if (rise) m_pend = 1;
      m_vsprev = vs; p_de = de; p_sof = n_sof; p_data = d; p_tim = {vb, hb, vs, hs};
    end
    #2;
    chk(beat_valid == e_valid, "R1 valid", 64'(beat_valid), 64'(e_valid));
    chk(beat_data == e_data, e_valid ? "R5 data" : "R2 idle data", 64'(beat_data), 64'(e_data));
    chk(beat_eol == e_eol, "R3 eol", 64'(beat_eol), 64'(e_eol));
    chk(beat_sof == e_sof, "R4 sof", 64'(beat_sof), 64'(e_sof));
    chk({tap_vblank, tap_hblank, tap_vsync, tap_hsync} == e_tim, "R6 taps",
        64'({tap_vblank, tap_hblank, tap_vsync, tap_hsync}), 64'(e_tim));
  endtask

  function automatic logic [29:0] nxt();
    seed = seed * 1103515245 + 12345;
    return 30'(seed >>> 2);
  endfunction

  task automatic line(input int len, input int gap);
    for (int p = 0; p < len; p++) step(1, 0, 0, 0, 0, nxt());
    for (int g = 0; g < gap; g++) step(0, g == 0, 0, 1, 0, nxt());
  endtask

  task automatic frame(input int lines, input int base, input int gap, input bit sync);
    for (int b = 0; b < 4; b++) step(0, 0, sync && (b == 1 || b == 2), 1, 1, nxt());
    for (int l = 0; l < lines; l++) line(base + (l % 3), gap);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1;
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, nxt());
    chk(beat_valid == 0 && beat_sof == 0 && beat_eol == 0 && beat_data == 0, "R7 reset outputs",
        64'(beat_data), 64'd0);
    rst = 0;
    // R7: vsync still high after reset is not an edge
    step(1, 0, 1, 0, 0, nxt());
    line(3, 2);
    for (int base = 1; base <= 4; base++)
      for (int gap = 1; gap <= 3; gap += 2) frame(4, base, gap, 1);
    // R3: back-to-back single-pixel lines
    frame(6, 1, 1, 1);
    // R4: vsync rise coinciding with an active pixel
    step(0, 0, 0, 0, 0, nxt());
    step(1, 0, 1, 0, 0, nxt());
    line(2, 1);
    // R7: reset mid-line with a pending edge, no sof afterwards until a new edge
    frame(2, 3, 2, 1);
    for (int b = 0; b < 2; b++) step(0, 0, b == 1, 1, 1, nxt());
    rst = 1; step(1, 0, 1, 0, 0, nxt()); step(1, 0, 0, 0, 0, nxt()); rst = 0;
    frame(3, 2, 1, 0);
    frame(3, 2, 1, 1);
    // R2: long run with enable low and changing data
    for (int i = 0; i < 8; i++) step(0, i[0], 0, 1, 1, nxt());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule